// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block forms the byte a host sees when it reads a flash device while an embedded program or erase algorithm is running, and it drives the active-low busy output. The command logic supplies the operation flags (program active, erase active), the algorithm busy flag, the time-limit flag, the erase-suspend state, a flag saying whether the current read address falls in a suspended sector, and a flag saying that the sector-erase collection window has closed. The block also receives the data byte being programmed and the array data that would be returned on a plain read.

Each read access is one event. An access starts when chip enable and output enable are both low, so whichever strobe falls last begins it. At that clock edge the block captures a status byte or array data into its output register and advances the toggle bits that apply. The output then holds until the next access. Polling software compares successive reads. A bit that keeps flipping means an algorithm is still running. A second toggle bit flips only while the host reads a sector whose erase is suspended.

Top module: `flash_wstat_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `status_o` becomes 0x00, `busy_n_o` becomes 1, and both toggle states return to 0. The first status read after reset therefore shows bits 6 and 2 as 0.
- R2: During an active program (`alg_busy_i`=1 and `op_prog_i`=1), bit 7 of a status read is the inverse of bit 7 of `wr_data_i`.
- R3: While an algorithm is active (program, or erase not suspended), bit 6 of each status read differs from bit 6 of the previous status read. The first read after reset shows 0.
- R4: Bit 6 advances only on reads taken while an algorithm is active. Reads of a suspended sector and array reads leave it unchanged.
- R5: Bit 2 advances only on reads that hit a suspended sector while no algorithm is active. During program or erase status reads it holds its last value.
- R6: During an active program or erase, bit 5 of a status read equals `time_out_i`.
- R7: During an active erase, bit 7 reads 0 and bit 3 equals `erase_begun_i`. During a program, bit 3 reads 0.
- R8: While erase is suspended and no algorithm is active, a read with `susp_sector_i`=1 returns bit 7 = 1, bits 5 and 3 = 0, and bit 6 at its held value.
- R9: When no algorithm is active and the read does not hit a suspended sector, the read returns `array_data_i` unchanged.
- R10: `busy_n_o` is 0 one clock after an edge where an algorithm is active. It is 1 one clock after an edge where none is active. An erase with `erase_susp_i`=1 counts as not active.
- R11: A read starts only on the clock edge where both strobes are first seen low. With one strobe low, or with both held low, `status_o` keeps its value and no toggle advances, even if the inputs change. Bits 4, 1 and 0 of a status byte are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_prog_i | input | 1 | A program operation is selected |
| op_erase_i | input | 1 | An erase operation is selected |
| alg_busy_i | input | 1 | The embedded algorithm engine is running |
| time_out_i | input | 1 | The operation has exceeded its time limit |
| erase_susp_i | input | 1 | Erase is suspended |
| susp_sector_i | input | 1 | The read address lies in a suspended sector |
| erase_begun_i | input | 1 | The sector-erase window has closed and erasure has begun |
| wr_data_i | input | DATA_W | Data being programmed |
| array_data_i | input | DATA_W | Array data for plain reads |
| ce_n_i | input | 1 | Chip enable strobe, active low |
| oe_n_i | input | 1 | Output enable strobe, active low |
| status_o | output | DATA_W | Byte captured at the last read start |
| busy_n_o | output | 1 | Busy indicator, low while an algorithm is active |

## Verification
A toggle state that advances wrongly shows up on the next status read as two equal consecutive bit-6 values. It can also show up as a bit-2 change during a program, and it is visible one clock after the read begins. A wrong source decode shows on that same read as a wrong bit 7, bit 3 or plain array data. A busy register decoded from the wrong inputs shows on `busy_n_o` one clock after the flags change. The vector walk runs through program, erase, suspend and suspend-program reads in a fixed order, so every expected toggle value follows from the reads that came before it.

// File: rtl/fsts_pkg.sv
package fsts_pkg;

    localparam int BYTE_W     = 8;
    localparam int POLL_BIT   = 7;
    localparam int RUN_TOG    = 6;
    localparam int LIMIT_BIT  = 5;
    localparam int WINDOW_BIT = 3;
    localparam int SUSP_TOG   = 2;

    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_PROG  = 2'd1,
        SRC_ERASE = 2'd2,
        SRC_SUSP  = 2'd3
    } src_e;

    typedef struct packed {
        logic prog;
        logic erase;
        logic busy;
        logic tmo;
        logic susp;
        logic in_susp;
        logic begun;
    } ctl_t;

    typedef struct packed {
        logic run;
        logic susp;
    } tog_t;

    function automatic logic engine_on(ctl_t c);
        return c.busy && (c.prog || (c.erase && !c.susp));
    endfunction

    function automatic src_e pick_src(ctl_t c);
        if (engine_on(c) && c.prog)
            return SRC_PROG;
        else if (engine_on(c))
            return SRC_ERASE;
        else if (c.susp && c.in_susp)
            return SRC_SUSP;
        else
            return SRC_ARRAY;
    endfunction

endpackage

// File: rtl/fsts_read_detect.sv
module fsts_read_detect (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    output logic rd_start
);
    logic rd_now;
    logic rd_prev;

    assign rd_now   = !ce_n && !oe_n;
    assign rd_start = rd_now && !rd_prev;

    always_ff @(posedge clk) begin
        if (rst) rd_prev <= 1'b0;
        else     rd_prev <= rd_now;
    end

    // R11: a read start is a single-cycle event
    assert_single_start_R11: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> !rd_start);

endmodule

// File: rtl/fsts_toggle_pair.sv
module fsts_toggle_pair
    import fsts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_start,
    input  logic adv_run,
    input  logic adv_susp,
    output tog_t tog
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tog <= '0;
        end else if (rd_start) begin
            if (adv_run)  tog.run  <= !tog.run;
            if (adv_susp) tog.susp <= !tog.susp;
        end
    end

    assert_run_flip_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_start && adv_run) |=> (tog.run != $past(tog.run)));

    assert_run_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(rd_start && adv_run) |=> $stable(tog.run));

    assert_susp_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(rd_start && adv_susp) |=> $stable(tog.susp));

endmodule

// File: rtl/fsts_compose.sv
module fsts_compose
    import fsts_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  src_e          src,
    input  ctl_t          ctl,
    input  tog_t          tog,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] word
);
    always_comb begin
        word = '0;
        unique case (src)
            SRC_PROG: begin
                word[POLL_BIT]  = !wr_data[POLL_BIT];
                word[RUN_TOG]   = tog.run;
                word[LIMIT_BIT] = ctl.tmo;
                word[SUSP_TOG]  = tog.susp;
            end
            SRC_ERASE: begin
                word[RUN_TOG]    = tog.run;
                word[LIMIT_BIT]  = ctl.tmo;
                word[WINDOW_BIT] = ctl.begun;
                word[SUSP_TOG]   = tog.susp;
            end
            SRC_SUSP: begin
                word[POLL_BIT] = 1'b1;
                word[RUN_TOG]  = tog.run;
                word[SUSP_TOG] = tog.susp;
            end
            default: word = array_data;
        endcase
    end

endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
    import fsts_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_prog_i,
    input  logic              op_erase_i,
    input  logic              alg_busy_i,
    input  logic              time_out_i,
    input  logic              erase_susp_i,
    input  logic              susp_sector_i,
    input  logic              erase_begun_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DATA_W-1:0] array_data_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] status_o,
    output logic              busy_n_o
);
    ctl_t              ctl;
    src_e              src;
    tog_t              tog;
    logic              rd_start;
    logic [DATA_W-1:0] word;

    assign ctl = '{prog: op_prog_i, erase: op_erase_i, busy: alg_busy_i,
                   tmo: time_out_i, susp: erase_susp_i,
                   in_susp: susp_sector_i, begun: erase_begun_i};
    assign src = pick_src(ctl);

    fsts_read_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n_i),
        .oe_n     (oe_n_i),
        .rd_start (rd_start)
    );

    fsts_toggle_pair u_toggle (
        .clk      (clk),
        .rst      (rst),
        .rd_start (rd_start),
        .adv_run  (src == SRC_PROG || src == SRC_ERASE),
        .adv_susp (src == SRC_SUSP),
        .tog      (tog)
    );

    fsts_compose #(.DW(DATA_W)) u_compose (
        .src        (src),
        .ctl        (ctl),
        .tog        (tog),
        .wr_data    (wr_data_i),
        .array_data (array_data_i),
        .word       (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
            busy_n_o <= 1'b1;
        end else begin
            if (rd_start) status_o <= word;
            busy_n_o <= !engine_on(ctl);
        end
    end

    assert_poll_inv_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_start && alg_busy_i && op_prog_i) |=>
            (status_o[POLL_BIT] != $past(wr_data_i[POLL_BIT])));

    assert_erase_poll_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_start && alg_busy_i && op_erase_i && !op_prog_i && !erase_susp_i) |=>
            !status_o[POLL_BIT]);

    assert_susp_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_start && !alg_busy_i && erase_susp_i && susp_sector_i) |=>
            (status_o[POLL_BIT] && !status_o[LIMIT_BIT] && !status_o[WINDOW_BIT]));

    assert_busy_low_R10: assert property (@(posedge clk) disable iff (rst)
        (alg_busy_i && op_prog_i) |=> !busy_n_o);

    assert_busy_release_R10: assert property (@(posedge clk) disable iff (rst)
        !alg_busy_i |=> busy_n_o);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_start |=> $stable(status_o));

endmodule

// File: tb/test_flash_wstat_gen.sv
module test_flash_wstat_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_prog_i, op_erase_i, alg_busy_i, time_out_i;
    logic       erase_susp_i, susp_sector_i, erase_begun_i;
    logic [7:0] wr_data_i, array_data_i;
    logic       ce_n_i, oe_n_i;
    logic [7:0] status_o;
    logic       busy_n_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = !clk;

    flash_wstat_gen i_flash_wstat_gen (
        .clk(clk), .rst(rst),
        .op_prog_i(op_prog_i), .op_erase_i(op_erase_i),
        .alg_busy_i(alg_busy_i), .time_out_i(time_out_i),
        .erase_susp_i(erase_susp_i), .susp_sector_i(susp_sector_i),
        .erase_begun_i(erase_begun_i),
        .wr_data_i(wr_data_i), .array_data_i(array_data_i),
        .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
        .status_o(status_o), .busy_n_o(busy_n_o)
    );

    // {prog,erase,busy,tmo,susp,in_susp,begun}, wr_data, array_data, expected byte, expected busy_n
    localparam int NV = 15;
    localparam logic [31:0] VEC [NV] = '{
        {7'b0000000, 8'h00, 8'hA5, 8'hA5, 1'b1},
        {7'b1010000, 8'h80, 8'h00, 8'h00, 1'b0},
        {7'b1010000, 8'h80, 8'h00, 8'h40, 1'b0},
        {7'b1011000, 8'h00, 8'h00, 8'hA0, 1'b0},
        {7'b0110000, 8'h00, 8'h00, 8'h40, 1'b0},
        {7'b0110001, 8'h00, 8'h00, 8'h08, 1'b0},
        {7'b0111001, 8'h00, 8'h00, 8'h68, 1'b0},
        {7'b0100110, 8'h00, 8'h00, 8'h80, 1'b1},
        {7'b0100110, 8'h00, 8'h00, 8'h84, 1'b1},
        {7'b0100100, 8'h00, 8'h3C, 8'h3C, 1'b1},
        {7'b1010110, 8'hFF, 8'h00, 8'h00, 1'b0},
        {7'b1010110, 8'hFF, 8'h00, 8'h40, 1'b0},
        {7'b0100110, 8'h00, 8'h00, 8'h80, 1'b1},
        {7'b0000000, 8'h00, 8'h5A, 8'h5A, 1'b1},
        {7'b0110110, 8'h00, 8'h00, 8'h84, 1'b1}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 9, 13:  return "R9";
            1, 2:      return "R2/R3";
            3:         return "R6";
            4, 5, 6:   return "R7/R3";
            7, 8, 12:  return "R8/R5";
            10, 11:    return "R5/R2";
            default:   return "R10/R4";
        endcase
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(logic [6:0] c, logic [7:0] wd, logic [7:0] ad);
        {op_prog_i, op_erase_i, alg_busy_i, time_out_i,
         erase_susp_i, susp_sector_i, erase_begun_i} = c;
        wr_data_i    = wd;
        array_data_i = ad;
    endtask

    task automatic do_read();
        @(negedge clk);
        ce_n_i = 1'b0;
        oe_n_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_read();
        ce_n_i = 1'b1;
        oe_n_i = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        ce_n_i = 1'b1;
        oe_n_i = 1'b1;
        set_ctl(7'b0, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        check8("R1 status", status_o, 8'h00);
        check8("R1 busy_n", {7'b0, busy_n_o}, 8'h01);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            set_ctl(VEC[i][31:25], VEC[i][24:17], VEC[i][16:9]);
            do_read();
            check8(tag_of(i), status_o, VEC[i][8:1]);
            check8("R10 busy_n", {7'b0, busy_n_o}, {7'b0, VEC[i][0]});
            end_read();
        end

        // R11: one strobe low is not a read; a held access captures once
        set_ctl(7'b1010000, 8'h00, 8'h00);
        @(negedge clk);
        oe_n_i = 1'b0;
        repeat (3) @(negedge clk);
        check8("R11 single strobe", status_o, 8'h84);
        ce_n_i = 1'b0;
        @(negedge clk);
        check8("R11 later strobe starts read", status_o, 8'h80);
        wr_data_i = 8'h80;
        repeat (4) @(negedge clk);
        check8("R11 held access", status_o, 8'h80);
        end_read();
        do_read();
        check8("R11 one advance per access", status_o, 8'h40);
        end_read();

        // R1: reset in the middle of a program
        rst = 1'b1;
        @(negedge clk);
        check8("R1 mid-op status", status_o, 8'h00);
        check8("R1 mid-op busy_n", {7'b0, busy_n_o}, 8'h01);
        rst = 1'b0;
        set_ctl(7'b1010000, 8'h00, 8'h00);
        do_read();
        check8("R1 toggles cleared", status_o, 8'h80);
        end_read();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule